// File: doc/BRIEF.md
# Timestamp-Matching Event Builder

This block collects hit packets arriving from many front-end sources and sorts them into event buffers by timestamp. Back-to-back packets that share a timestamp go into the same buffer. A buffer closes when a packet with a different timestamp arrives, when it reaches its packet limit, or when no packet has come in for a set number of cycles. Two buffers take turns, so one can fill while the host drains the other.

The host sees a flag when a closed buffer is waiting. It reads that buffer at word addresses and then frees it with a release strobe. Buffers are always handed out in the order they closed. A bank of saturating counters, one per low source-address nibble, counts the accepted packets. The host reads these counters through a select input and clears all of them at once with a strobe.

Top module: `tsevt_builder`

## Requirements
- R1: An input packet is 104 bits. Bits [103:80] hold the timestamp, bits [79:64] hold the source address, and bits [63:0] hold the hit pattern. A packet is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- R2: Packets accepted one after another with an equal timestamp are stored in the same buffer. Readout word 0 is the header: bits [31:8] hold the timestamp and bits [7:0] hold the packet count.
- R3: When a buffer is open and a packet arrives with a different timestamp, that buffer is closed. The new packet becomes the first entry of the other buffer, and `buf_ready` is high on the next cycle.
- R4: A buffer closes on its 64th packet. The next packet, even with the same timestamp, starts a new buffer with a count of 1.
- R5: An open buffer closes when 256 clock edges pass after its last accepted packet with no packet accepted in between. `buf_ready` is low after 255 such edges and high after 256.
- R6: For packet k of the buffer (k = 0, 1, ...), the packet is zero-extended to 128 bits. Its words sit at read addresses 1+4k to 4+4k, most significant word first. `rd_data` shows the word for `rd_addr` one clock after the address is applied.
- R7: `buf_ready` is high while a closed buffer is waiting. Reads address the oldest closed buffer. A `buf_release` pulse frees that buffer, and reads then address the next closed buffer in closing order.
- R8: `in_ready` is low in two cases. The first is when both buffers are closed and not yet released. The second is when one buffer waits for release, the other is open, and the offered packet's timestamp differs from the open buffer's timestamp. A matching packet is still accepted.
- R9: Each accepted packet increments counter number src[3:0]. `sc_count` shows the counter picked by `sc_sel` in the same cycle.
- R10: A counter stops at its all-ones value and does not wrap.
- R11: `sc_clear` zeroes every counter on the next edge. If a packet is accepted on the same edge, it is not counted.
- R12: After reset, `in_ready` is 1, `buf_ready` is 0 and every counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Block accepts the offered packet |
| in_pkt | input | 104 | Packet: timestamp, source, hits |
| buf_ready | output | 1 | A closed buffer awaits the host |
| buf_release | input | 1 | Host frees the oldest closed buffer |
| rd_addr | input | 9 | Word address inside the readable buffer |
| rd_data | output | 32 | Word at the address from one cycle before |
| sc_sel | input | 4 | Counter select |
| sc_clear | input | 1 | Zero all counters |
| sc_count | output | 16 | Selected counter value |

## Verification
Some rules are checked by properties on every cycle. These cover the stall whenever both buffers are held, a closed buffer showing up after a timestamp change or a 64th packet, the idle timeout firing at its limit, the read side moving on after a release, and counters that never step down except on a clear. Other behaviour can only be shown by the directed scenarios, because it depends on actual contents. That covers the header and packet words read back from memory, the order in which buffers are handed out, the exact timeout edge, counter saturation after hundreds of packets, and the clear winning over a concurrent packet.

// File: rtl/tsevt_pkg.sv
package tsevt_pkg;
    localparam int TS_W      = 24;
    localparam int SRC_W     = 16;
    localparam int HIT_W     = 64;
    localparam int PKT_W     = TS_W + SRC_W + HIT_W;
    localparam int WORD_W    = 32;
    localparam int PKT_WORDS = (PKT_W + WORD_W - 1) / WORD_W;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [SRC_W-1:0] src;
        logic [HIT_W-1:0] hits;
    } pkt_t;
endpackage

// File: rtl/tsevt_store.sv
module tsevt_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 104,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_buf,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_buf,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 2 ** (SLOT_W + 1);

    logic [DATA_W-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_buf, wr_slot}] <= wr_data;
    end

    assign rd_data = mem_q[{rd_buf, rd_slot}];
endmodule

// File: rtl/tsevt_scalers.sv
module tsevt_scalers #(
    parameter int N = 16,
    parameter int W = 16,
    localparam int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [SEL_W-1:0] inc_idx,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic [W-1:0]     count
);
    logic [N-1:0][W-1:0] sc_d, sc_q;

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic hit;
        assign hit = inc && (inc_idx == SEL_W'(g)) && !(&sc_q[g]);
        assign sc_d[g] = clear ? '0 : (hit ? sc_q[g] + W'(1) : sc_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign count = sc_q[sel];
endmodule

// File: rtl/tsevt_builder.sv
module tsevt_builder
    import tsevt_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int IDLE_LIM = 256,
    parameter int SC_N     = 16,
    parameter int SC_W     = 16,
    localparam int SLOT_W  = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int IDLE_W  = $clog2(IDLE_LIM),
    localparam int SEL_W   = $clog2(SC_N),
    localparam int RADDR_W = $clog2(1 + PKT_WORDS * DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PKT_W-1:0]   in_pkt,
    output logic               buf_ready,
    input  logic               buf_release,
    input  logic [RADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    input  logic [SEL_W-1:0]   sc_sel,
    input  logic               sc_clear,
    output logic [SC_W-1:0]    sc_count
);
    localparam int WSEL_W = $clog2(PKT_WORDS);
    localparam int PAD_W  = PKT_WORDS * WORD_W - PKT_W;
    localparam int HCNT_W = WORD_W - TS_W;

    typedef struct packed {
        logic                       open;
        logic                       wbuf;
        logic                       rbuf;
        logic [1:0]                 done;
        logic [CNT_W-1:0]           cnt;
        logic [TS_W-1:0]            ts;
        logic [IDLE_W-1:0]          idle;
        logic [1:0][TS_W-1:0]       bts;
        logic [1:0][CNT_W-1:0]      bcnt;
        logic [WORD_W-1:0]          rdata;
    } st_t;

    st_t st_d, st_q;

    pkt_t                        pkt;
    logic                        ts_hit, acc;
    logic                        wr_en, wr_buf;
    logic [SLOT_W-1:0]           wr_slot, rd_slot;
    logic [CNT_W-1:0]            new_cnt;
    logic [RADDR_W-1:0]          rd_k;
    logic [WSEL_W-1:0]           rd_w;
    logic [PKT_W-1:0]            rd_pkt;
    logic [PKT_WORDS*WORD_W-1:0] rd_pad;

    // signals brought out for the bound checker
    logic [1:0]        chk_done;
    logic              chk_open, chk_rbuf;
    logic [CNT_W-1:0]  chk_cnt;
    logic [TS_W-1:0]   chk_ts;
    logic [IDLE_W-1:0] chk_idle;

    assign pkt      = pkt_t'(in_pkt);
    assign ts_hit   = st_q.open && (pkt.ts == st_q.ts);
    assign in_ready = !st_q.done[st_q.wbuf] &&
                      (!st_q.open || !st_q.done[~st_q.wbuf] || ts_hit);
    assign acc      = in_valid && in_ready;

    assign rd_k    = rd_addr - RADDR_W'(1);
    assign rd_w    = rd_k[WSEL_W-1:0];
    assign rd_slot = SLOT_W'(rd_k >> WSEL_W);
    assign rd_pad  = {{PAD_W{1'b0}}, rd_pkt};

    tsevt_store #(.DEPTH(DEPTH), .DATA_W(PKT_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_buf  (wr_buf),
        .wr_slot (wr_slot),
        .wr_data (in_pkt),
        .rd_buf  (st_q.rbuf),
        .rd_slot (rd_slot),
        .rd_data (rd_pkt)
    );

    tsevt_scalers #(.N(SC_N), .W(SC_W)) u_scal (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (acc),
        .inc_idx (pkt.src[SEL_W-1:0]),
        .clear   (sc_clear),
        .sel     (sc_sel),
        .count   (sc_count)
    );

    always_comb begin
        st_d    = st_q;
        wr_en   = acc;
        wr_buf  = st_q.wbuf;
        wr_slot = '0;
        new_cnt = '0;

        if (acc) begin
            st_d.idle = '0;
            if (st_q.open && !ts_hit) begin
                // timestamp changed: seal current, start the other buffer
                st_d.done[st_q.wbuf] = 1'b1;
                st_d.bts[st_q.wbuf]  = st_q.ts;
                st_d.bcnt[st_q.wbuf] = st_q.cnt;
                wr_buf    = ~st_q.wbuf;
                st_d.wbuf = ~st_q.wbuf;
                st_d.cnt  = CNT_W'(1);
                st_d.ts   = pkt.ts;
                st_d.open = 1'b1;
            end else begin
                wr_slot   = st_q.open ? SLOT_W'(st_q.cnt) : '0;
                new_cnt   = st_q.open ? st_q.cnt + CNT_W'(1) : CNT_W'(1);
                st_d.ts   = pkt.ts;
                st_d.cnt  = new_cnt;
                st_d.open = 1'b1;
                if (new_cnt == CNT_W'(DEPTH)) begin
                    st_d.done[st_q.wbuf] = 1'b1;
                    st_d.bts[st_q.wbuf]  = pkt.ts;
                    st_d.bcnt[st_q.wbuf] = new_cnt;
                    st_d.wbuf = ~st_q.wbuf;
                    st_d.open = 1'b0;
                    st_d.cnt  = '0;
                end
            end
        end else if (st_q.open) begin
            if (st_q.idle == IDLE_W'(IDLE_LIM - 1)) begin
                st_d.done[st_q.wbuf] = 1'b1;
                st_d.bts[st_q.wbuf]  = st_q.ts;
                st_d.bcnt[st_q.wbuf] = st_q.cnt;
                st_d.wbuf = ~st_q.wbuf;
                st_d.open = 1'b0;
                st_d.cnt  = '0;
                st_d.idle = '0;
            end else begin
                st_d.idle = st_q.idle + IDLE_W'(1);
            end
        end

        if (buf_release && st_q.done[st_q.rbuf]) begin
            st_d.done[st_q.rbuf] = 1'b0;
            st_d.rbuf = ~st_q.rbuf;
        end

        if (rd_addr == '0)
            st_d.rdata = {st_q.bts[st_q.rbuf], HCNT_W'(st_q.bcnt[st_q.rbuf])};
        else
            st_d.rdata = rd_pad[(PKT_WORDS - 1 - int'(rd_w)) * WORD_W +: WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_ready = st_q.done[st_q.rbuf];
    assign rd_data   = st_q.rdata;

    assign chk_done = st_q.done;
    assign chk_open = st_q.open;
    assign chk_rbuf = st_q.rbuf;
    assign chk_cnt  = st_q.cnt;
    assign chk_ts   = st_q.ts;
    assign chk_idle = st_q.idle;
endmodule

// File: rtl/tsevt_builder_chk.sv
module tsevt_builder_chk
    import tsevt_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int IDLE_LIM = 256,
    parameter int CNT_W    = 7,
    parameter int IDLE_W   = 8,
    parameter int SEL_W    = 4,
    parameter int SC_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [PKT_W-1:0]  in_pkt,
    input logic              buf_ready,
    input logic              buf_release,
    input logic [SEL_W-1:0]  sc_sel,
    input logic              sc_clear,
    input logic [SC_W-1:0]   sc_count,
    input logic [1:0]        done,
    input logic              open,
    input logic              rbuf,
    input logic [CNT_W-1:0]  cnt,
    input logic [TS_W-1:0]   cur_ts,
    input logic [IDLE_W-1:0] idle
);
    logic [TS_W-1:0] in_ts;
    logic            acc;
    assign in_ts = in_pkt[PKT_W-1 -: TS_W];
    assign acc   = in_valid && in_ready;

    // R8
    both_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&done) |-> !in_ready);

    // R3
    ts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && open && in_ts != cur_ts) |=> buf_ready);

    // R4
    fill_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && open && in_ts == cur_ts && cnt == CNT_W'(DEPTH - 1)) |=> (buf_ready && !open));

    // R5
    idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && !acc && idle == IDLE_W'(IDLE_LIM - 1)) |=> (buf_ready && !open));

    // R7
    release_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_release && buf_ready) |=> (rbuf != $past(rbuf)));

    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_clear |=> (sc_count == '0));

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sc_clear) && $stable(sc_sel)) |-> (sc_count >= $past(sc_count)));
endmodule

bind tsevt_builder tsevt_builder_chk #(
    .DEPTH(DEPTH), .IDLE_LIM(IDLE_LIM), .CNT_W(CNT_W),
    .IDLE_W(IDLE_W), .SEL_W(SEL_W), .SC_W(SC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .buf_ready(buf_ready), .buf_release(buf_release),
    .sc_sel(sc_sel), .sc_clear(sc_clear), .sc_count(sc_count),
    .done(chk_done), .open(chk_open), .rbuf(chk_rbuf), .cnt(chk_cnt),
    .cur_ts(chk_ts), .idle(chk_idle)
);

// File: tb/test_tsevt_builder.sv
module test_tsevt_builder;
    localparam int SCW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [103:0] in_pkt = '0;
    logic         buf_ready;
    logic         buf_release = 1'b0;
    logic [8:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [3:0]   sc_sel = '0;
    logic         sc_clear = 1'b0;
    logic [SCW-1:0] sc_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tsevt_builder #(.SC_W(SCW)) i_tsevt_builder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pkt(in_pkt), .buf_ready(buf_ready), .buf_release(buf_release),
        .rd_addr(rd_addr), .rd_data(rd_data), .sc_sel(sc_sel),
        .sc_clear(sc_clear), .sc_count(sc_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [103:0] p, input int w);
        logic [127:0] x;
        x = {24'h0, p};
        return x[127 - 32*w -: 32];
    endfunction

    function automatic logic [103:0] mk(input logic [23:0] ts, input logic [15:0] src,
                                        input logic [63:0] hits);
        return {ts, src, hits};
    endfunction

    task automatic send(input logic [103:0] p);
        @(negedge clk);
        in_pkt = p;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] w);
        @(negedge clk);
        rd_addr = 9'(a);
        @(negedge clk);
        w = rd_data;
    endtask

    task automatic release_buf();
        @(negedge clk);
        buf_release = 1'b1;
        @(negedge clk);
        buf_release = 1'b0;
    endtask

    task automatic clear_sc();
        @(negedge clk);
        sc_clear = 1'b1;
        @(negedge clk);
        sc_clear = 1'b0;
    endtask

    task automatic sc_read(input int s, output logic [SCW-1:0] v);
        @(negedge clk);
        sc_sel = 4'(s);
        #1 v = sc_count;
    endtask

    task automatic drain();
        repeat (300) @(negedge clk);
        while (buf_ready) release_buf();
    endtask

    task automatic t_reset();
        logic [SCW-1:0] v;
        @(negedge clk);
        chk("R12 in_ready", 64'(in_ready), 64'd1);
        chk("R12 buf_ready", 64'(buf_ready), 64'd0);
        for (int s = 0; s < 16; s++) begin
            sc_read(s, v);
            chk("R12 counter", 64'(v), 64'd0);
        end
    endtask

    task automatic t_group();
        logic [103:0] p0, p1, p2, p3;
        logic [31:0] w;
        logic [SCW-1:0] v;
        drain();
        clear_sc();
        p0 = mk(24'h123456, 16'h0011, 64'hA5A5_0000_1111_0001);
        p1 = mk(24'h123456, 16'h0012, 64'h0BAD_CAFE_0000_0002);
        p2 = mk(24'h123456, 16'h0013, 64'hDEAD_BEEF_3333_0003);
        p3 = mk(24'h123457, 16'h0023, 64'h0000_0000_0000_0004);
        send(p0); send(p1); send(p2);
        chk("R2 open not ready", 64'(buf_ready), 64'd0);
        send(p3);
        chk("R3 close on ts change", 64'(buf_ready), 64'd1);
        rd(0, w);
        chk("R2 header", 64'(w), 64'h1234_5603);
        rd(1, w);
        chk("R1 R6 word0 of pkt0", 64'(w), 64'(exp_word(p0, 0)));
        rd(4, w);
        chk("R6 word3 of pkt0", 64'(w), 64'(exp_word(p0, 3)));
        rd(10, w);
        chk("R1 R6 src word of pkt2", 64'(w), 64'(exp_word(p2, 1)));
        rd(7, w);
        chk("R6 word2 of pkt1", 64'(w), 64'(exp_word(p1, 2)));
        release_buf();
        chk("R7 released", 64'(buf_ready), 64'd0);
        repeat (260) @(negedge clk);
        chk("R7 second buffer", 64'(buf_ready), 64'd1);
        rd(0, w);
        chk("R3 new buffer header", 64'(w), 64'h1234_5701);
        rd(1, w);
        chk("R3 new buffer first word", 64'(w), 64'(exp_word(p3, 0)));
        release_buf();
        sc_read(1, v); chk("R9 counter 1", 64'(v), 64'd1);
        sc_read(3, v); chk("R9 counter 3", 64'(v), 64'd2);
        sc_read(0, v); chk("R9 counter 0", 64'(v), 64'd0);
    endtask

    task automatic t_timeout();
        drain();
        send(mk(24'h00_0777, 16'h0001, 64'h1));
        repeat (255) @(posedge clk);
        #1 chk("R5 before limit", 64'(buf_ready), 64'd0);
        @(posedge clk);
        #1 chk("R5 at limit", 64'(buf_ready), 64'd1);
        release_buf();
    endtask

    task automatic t_full();
        logic [31:0] w;
        drain();
        for (int i = 0; i < 64; i++) begin
            send(mk(24'h5EABCD, 16'(i), 64'(i)));
            if (i == 62) chk("R4 63 not closed", 64'(buf_ready), 64'd0);
        end
        chk("R4 closed at 64", 64'(buf_ready), 64'd1);
        rd(0, w);
        chk("R4 header count 64", 64'(w), 64'h5EAB_CD40);
        rd(256, w);
        chk("R6 last word", 64'(w), 64'd63);
        send(mk(24'h5EABCD, 16'h0099, 64'h99));
        release_buf();
        chk("R4 new buffer open", 64'(buf_ready), 64'd0);
        repeat (260) @(negedge clk);
        rd(0, w);
        chk("R4 same ts new buffer", 64'(w), 64'h5EAB_CD01);
        rd(1, w);
        chk("R6 top word", 64'(w), 64'h0000_005E);
        release_buf();
    endtask

    task automatic t_backpressure();
        logic [31:0] w;
        drain();
        send(mk(24'h000100, 16'h0001, 64'hA));
        send(mk(24'h000200, 16'h0002, 64'hB));
        @(negedge clk);
        in_pkt = mk(24'h000300, 16'h0003, 64'hC);
        #1 chk("R8 mismatch stalled", 64'(in_ready), 64'd0);
        in_pkt = mk(24'h000200, 16'h0004, 64'hD);
        #1 chk("R8 match accepted", 64'(in_ready), 64'd1);
        send(mk(24'h000200, 16'h0004, 64'hD));
        repeat (260) @(negedge clk);
        #1 chk("R8 both held", 64'(in_ready), 64'd0);
        rd(0, w);
        chk("R7 oldest first", 64'(w), 64'h0001_0001);
        release_buf();
        rd(0, w);
        chk("R7 next in order", 64'(w), 64'h0002_0002);
        release_buf();
        chk("R7 none left", 64'(buf_ready), 64'd0);
        #1 chk("R8 ready again", 64'(in_ready), 64'd1);
    endtask

    task automatic t_scalers();
        logic [SCW-1:0] v;
        drain();
        clear_sc();
        @(negedge clk);
        in_pkt = mk(24'h000900, 16'h0007, 64'h7);
        in_valid = 1'b1;
        sc_clear = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        sc_clear = 1'b0;
        sc_read(7, v);
        chk("R11 clear beats packet", 64'(v), 64'd0);
        for (int i = 0; i < 260; i++) begin
            send(mk(24'(i + 'h1000), 16'h0005, 64'(i)));
            if (buf_ready) release_buf();
        end
        sc_read(5, v);
        chk("R10 saturated", 64'(v), 64'hFF);
        sc_read(6, v);
        chk("R9 other counter untouched", 64'(v), 64'd0);
        clear_sc();
        sc_read(5, v);
        chk("R11 cleared", 64'(v), 64'd0);
        drain();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_group();
        t_timeout();
        t_full();
        t_backpressure();
        t_scalers();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule